// File: doc/BRIEF.md
# Processor Tick Timer

This block is a tick timer for a small processor core. It holds two 32-bit registers: a count register, and a control word. The control word packs a period value, an interrupt enable, a sticky interrupt flag and a two-bit operating mode. Each cycle in which the `tick` strobe is high, an active timer adds one to its count. The reference tick rate is 20 MHz, and the strobe comes from that divided clock.

After each increment, the new count is checked against the period. Only the low `PER_W` bits of the count take part in this check. On a hit, the flag is set if interrupts are enabled. The mode then decides what the counter does next:
- wrap back to zero;
- freeze;
- carry on counting through the match.

Software reaches both registers through a single-cycle write port and a combinational read port. The interrupt line follows the flag.

Top module: `tick_timer`

## Requirements
- R1: After reset, the control word and the count both read 0 and `irq` is low.
- R2: While the mode field (control bits [31:30]) is 00, the count does not change and no match occurs, whatever `tick` does.
- R3: In an active mode, the count rises by exactly 1, modulo 2^CNT_W, in each cycle with `tick` high and no write. In a cycle with `tick` low, the count is unchanged.
- R4: A match occurs when the count after an increment equals control bits [PER_W-1:0] in its low PER_W bits. Count bits at or above PER_W, and control bits [27:PER_W], do not affect it.
- R5: On a match with the enable bit (control bit 29) set, the pending bit (control bit 28) becomes 1 in the next cycle. With the enable bit clear, the pending bit is left alone.
- R6: The pending bit is sticky. It changes only when software writes the control word, and `irq` always equals it.
- R7: In mode 01 (restart), a match loads 0 into the count instead of the incremented value.
- R8: In mode 10 (one-shot), a match stores the matching value, and the count then stays there until the control word is written again.
- R9: In mode 11 (continuous), a match does not disturb counting. The count runs on past the match value and wraps from 2^CNT_W-1 to 0.
- R10: A count write (`wr_sel`=1) puts `wr_data[CNT_W-1:0]` into the count on the next edge. It overrides any increment, and no match is evaluated in that cycle.
- R11: A control write (`wr_sel`=0) stores all 32 bits of `wr_data`, holds the count for that cycle, and re-arms counting in any nonzero mode. `rd_data` returns the control word when `rd_sel`=0 and the zero-extended count when `rd_sel`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count strobe, one pulse per timer tick |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 control word, 1 count |
| wr_data | input | 32 | Write data |
| rd_sel | input | 1 | Read target: 0 control word, 1 count |
| rd_data | output | 32 | Read data |
| irq | output | 1 | Timer interrupt, equal to the pending bit |

## Verification
The assertions assume that `rst_n` is held low for at least one edge before any checked behaviour. They also assume that a write and a tick arriving together resolve in favour of the write. The bench therefore drives `tick` both alone and together with writes. The bench parameterizes the block with an 8-bit count and a 4-bit period, so every period value and the count wrap can be reached within a few dozen ticks. Inputs change only on falling edges, one write at most per cycle. Garbage is placed in the ignored control bits so that the masking is exercised by the stimulus itself.

// File: rtl/tick_timer.sv
module tick_timer #(
  parameter int CNT_W = 32,
  parameter int PER_W = 28
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_sel,
  output logic [31:0] rd_data,
  output logic        irq
);

  localparam logic [1:0] M_OFF  = 2'b00;
  localparam logic [1:0] M_RST  = 2'b01;
  localparam logic [1:0] M_ONE  = 2'b10;
  localparam logic [1:0] M_CONT = 2'b11;
  localparam int PEND_BIT = 28;
  localparam int IE_BIT   = 29;

  logic [31:0]      ctl_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;

  logic [1:0]       mode;
  logic             ie;
  logic             wr_ctl, wr_cnt, counting, hit;
  logic [CNT_W-1:0] cnt_inc;

  assign mode     = ctl_q[31:30];
  assign ie       = ctl_q[IE_BIT];
  assign wr_ctl   = wr_en & ~wr_sel;
  assign wr_cnt   = wr_en & wr_sel;
  assign counting = tick & run_q & (mode != M_OFF) & ~wr_en;
  assign cnt_inc  = cnt_q + 1'b1;
  assign hit      = counting & (cnt_inc[PER_W-1:0] == ctl_q[PER_W-1:0]);

  assign irq     = ctl_q[PEND_BIT];
  assign rd_data = rd_sel ? 32'(cnt_q) : ctl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
    end else begin
      if (wr_ctl) begin
        ctl_q <= wr_data;
        run_q <= 1'b1;
      end else if (hit && ie) begin
        ctl_q[PEND_BIT] <= 1'b1;
      end

      if (hit && mode == M_ONE)
        run_q <= 1'b0;

      if (wr_cnt)
        cnt_q <= wr_data[CNT_W-1:0];
      else if (counting)
        cnt_q <= (hit && mode == M_RST) ? '0 : cnt_inc;
    end
  end

  a_r2_off_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF && !wr_en) |=> $stable(cnt_q));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_en) |=> $stable(cnt_q));

  a_r5_pend_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ie) |=> irq);

  a_r6_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !wr_ctl) |=> irq);

  a_r6_pend_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !wr_ctl && !(hit && ie)) |=> !irq);

  a_r7_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == M_RST) |=> (cnt_q == '0));

  a_r8_oneshot_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_ONE && !run_q && !wr_en) |=> $stable(cnt_q));

  a_r9_cont_runs: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && mode == M_CONT) |=> (cnt_q == $past(cnt_inc)));

  a_r10_cnt_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> (cnt_q == $past(wr_data[CNT_W-1:0])));

  a_r11_ctl_load: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> (ctl_q == $past(wr_data) && $stable(cnt_q)));

endmodule

// File: tb/tb_tick_timer.sv
module tb_tick_timer;
  localparam int CW = 8;
  localparam int PW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq;

  int n_vec = 0;
  int n_bad = 0;

  logic [31:0] m_ctl;
  int unsigned m_cnt;
  logic        m_run;

  tick_timer #(.CNT_W(CW), .PER_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq));

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic observe(input string cnt_req);
    rd_sel = 1'b1; #1;
    chk(cnt_req, rd_data, m_cnt);
    rd_sel = 1'b0; #1;
    chk("R11 control readback", rd_data, m_ctl);
    chk("R6 irq follows pending", {31'b0, irq}, {31'b0, m_ctl[28]});
  endtask

  // Spec model: one cycle of requirements R2..R11
  task automatic step(input logic t, input logic w, input logic s,
                      input logic [31:0] d, input string cnt_req);
    int unsigned nxt;
    tick = t; wr_en = w; wr_sel = s; wr_data = d;
    if (w && !s) begin
      m_ctl = d; m_run = 1'b1;
    end else if (w && s) begin
      m_cnt = d % (1 << CW);
    end else if (t && m_run && m_ctl[31:30] != 2'b00) begin
      nxt = (m_cnt + 1) % (1 << CW);
      if ((nxt % (1 << PW)) == (m_ctl % (1 << PW))) begin
        if (m_ctl[29]) m_ctl[28] = 1'b1;
        case (m_ctl[31:30])
          2'b01: nxt = 0;
          2'b10: m_run = 1'b0;
          default: ;
        endcase
      end
      m_cnt = nxt;
    end
    @(posedge clk); @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    observe(cnt_req);
  endtask

  function automatic logic [31:0] ctl(input logic [1:0] md, input logic ie,
                                      input logic pd, input logic [3:0] per);
    return {md, ie, pd, 24'h5A3C96, per};
  endfunction

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    string rq;
    m_ctl = '0; m_cnt = 0; m_run = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    observe("R1 reset count");

    // R2: mode 00 holds count even with ticks and a loaded value
    step(1'b0, 1'b1, 1'b1, 32'h33, "R10 count load");
    for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 1'b0, '0, "R2 disabled hold");

    // Sweep: every active mode, period and enable setting (R3 R4 R5 R7 R8 R9)
    for (int md = 1; md < 4; md++)
      for (int per = 0; per < 16; per++)
        for (int ie = 0; ie < 2; ie++) begin
          rq = (md == 1) ? "R7 restart count" : (md == 2) ? "R8 one-shot count" : "R9 continuous count";
          step(1'b0, 1'b1, 1'b1, 32'hFFFF_FF00 | 32'(per * 7 % 16), "R10 count load");
          step(1'b0, 1'b1, 1'b0, ctl(md[1:0], ie[0], 1'b0, per[3:0]), "R11 hold on control write");
          for (int i = 0; i < 40; i++)
            step((i % 3) != 2, 1'b0, 1'b0, '0, rq);
          step(1'b0, 1'b1, 1'b0, ctl(md[1:0], ie[0], 1'b0, per[3:0]), "R6 pending cleared by write");
        end

    // R9: continuous wrap past 2^CNT_W-1
    step(1'b0, 1'b1, 1'b1, 32'd250, "R10 count load");
    step(1'b0, 1'b1, 1'b0, ctl(2'b11, 1'b1, 1'b0, 4'h3), "R11 hold on control write");
    for (int i = 0; i < 12; i++) step(1'b1, 1'b0, 1'b0, '0, "R9 wrap");

    // R10: count write overrides a simultaneous tick
    step(1'b1, 1'b1, 1'b1, 32'd14, "R10 write beats tick");
    step(1'b1, 1'b0, 1'b0, '0, "R3 increment after load");

    // R6: software can set and clear pending directly
    step(1'b0, 1'b1, 1'b0, ctl(2'b00, 1'b0, 1'b1, 4'h0), "R6 pending set by write");
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, '0, "R2 disabled hold");
    step(1'b0, 1'b1, 1'b0, ctl(2'b00, 1'b0, 1'b0, 4'h0), "R6 pending clear");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule